// File: doc/BRIEF.md
# Three-Mode Power State Controller

This controller moves a chip among three power modes: running, idle (processor halted, everything else running) and deep sleep (regulator off, pad outputs frozen). Software asks for idle or deep sleep with one-cycle request pulses. Idle ends on any interrupt or on a debug-port wake command.

Deep sleep is entered through a fixed sequence:
1. A state-save handshake runs.
2. The pad outputs are frozen.
3. The regulator enable is dropped.

Wake-up runs the reverse sequence:
1. The regulator is turned back on.
2. A fixed settle time passes.
3. A state-restore handshake runs.
4. The pads are unfrozen.

Five sources can end deep sleep, and each has its own enable bit:
- sleep timer
- external interrupt
- debug wake
- serial-line activity
- GPIO activity

Every enabled source event seen from deep sleep until the restore completes is collected into a sticky cause register. Software clears that register by writing ones while running. The serial receiver is held off while the chip is frozen or waking. When wake-up completes, the receiver gets a one-cycle reset so that any partial byte is dropped.

The save and restore engines are attached through level handshakes. A request stays high until its matching done pulse is sampled, so the engines can take any number of cycles.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `pwr_mode` is 0 (running), `cpu_halt` is 0, `reg_en` is 1, `gpio_freeze` is 0, both handshake requests are 0, `ser_rx_en` is 1 and `wake_cause` is 0.
- R2: While running, a `req_idle` pulse moves the controller to idle on the next cycle (`pwr_mode`=1, `cpu_halt`=1, `reg_en`=1). Idle is left only when some bit of `irq_lines`, `ext_irq`, `tmr_wake` or `dbg_wake` is high; `ser_act` and `gpio_act` do not end idle.
- R3: A `req_deep` pulse while running wins over a simultaneous `req_idle`. It raises `save_req` and `cpu_halt`. `save_req` stays high until `save_done` is sampled.
- R4: `gpio_freeze` rises only in the cycle after `save_done`. `reg_en` stays high for that one cycle and falls on the cycle after.
- R5: In deep sleep, `reg_en` is 0, `gpio_freeze` is 1, `cpu_halt` is 1 and `pwr_mode` is 2. `pwr_mode` stays 2 for the whole entry, sleep and wake-up sequence.
- R6: Wake-source bit positions are: 0 timer, 1 external interrupt, 2 debug wake, 3 serial activity, 4 GPIO activity. A source whose `wake_en` bit is 0 neither ends deep sleep nor sets its `wake_cause` bit.
- R7: An enabled source event in deep sleep raises `reg_en` on the next cycle. `gpio_freeze` stays high. `restore_req` rises exactly SETTLE_CYC cycles later and is held until `restore_done` is sampled.
- R8: On `restore_done`, the next cycle shows `pwr_mode`=0, `gpio_freeze`=0 and `cpu_halt`=0.
- R9: Every enabled source event seen during sleep, settle or restore sets its `wake_cause` bit, not only the first one. The bits are sticky.
- R10: While running, a 1 on a `cause_clr` bit clears that `wake_cause` bit on the next cycle. In every other state `cause_clr` has no effect.
- R11: `ser_rx_en` is 0 while `gpio_freeze` is 1. On the first running cycle after a restore, `ser_rx_rst` is 1 for exactly one cycle with `ser_rx_en` still 0. `ser_rx_en` returns to 1 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_idle | input | 1 | Software request for idle (pulse) |
| req_deep | input | 1 | Software request for deep sleep (pulse) |
| irq_lines | input | N_IRQ | Interrupt lines that end idle |
| tmr_wake | input | 1 | Sleep-timer wake event (source 0) |
| ext_irq | input | 1 | External interrupt (source 1) |
| dbg_wake | input | 1 | Debug-port wake command (source 2) |
| ser_act | input | 1 | Serial-line activity (source 3) |
| gpio_act | input | 1 | GPIO activity (source 4) |
| wake_en | input | 5 | Per-source deep-sleep wake enable |
| cause_clr | input | 5 | Write-one-to-clear strobe for wake_cause |
| save_done | input | 1 | State-save engine finished |
| restore_done | input | 1 | State-restore engine finished |
| cpu_halt | output | 1 | Processor halted |
| reg_en | output | 1 | Core regulator enable |
| gpio_freeze | output | 1 | Hold pad outputs at last value |
| save_req | output | 1 | State-save request (held) |
| restore_req | output | 1 | State-restore request (held) |
| ser_rx_en | output | 1 | Serial receiver enable |
| ser_rx_rst | output | 1 | One-cycle serial receiver reset |
| wake_cause | output | 5 | Sticky collected wake causes |
| pwr_mode | output | 2 | 0 running, 1 idle, 2 deep sleep sequence |

## Verification
The embedded properties watch, on every cycle:
- that each handshake request is held until its done pulse;
- that the freeze rises only after a save done and falls only after a restore done;
- that the regulator is off only while frozen and halted;
- that the receiver is disabled while frozen;
- that cause bits rise only for enabled sources and never fall outside running mode.

Other behaviour needs the bench scenarios:
- the exact settle length;
- the request priority;
- which sources end idle;
- the full cause set accumulated across sleep, settle and restore, which a scoreboard compares on every return to running;
- the clear strobe being ignored while asleep.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned N_WSRC    = 5;
  localparam int unsigned WS_TIMER  = 0;
  localparam int unsigned WS_EXTIRQ = 1;
  localparam int unsigned WS_DEBUG  = 2;
  localparam int unsigned WS_SERIAL = 3;
  localparam int unsigned WS_GPIO   = 4;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SAVE    = 3'd2,
    ST_FREEZE  = 3'd3,
    ST_SLEEP   = 3'd4,
    ST_SETTLE  = 3'd5,
    ST_RESTORE = 3'd6
  } pmc_state_e;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_DEEP = 2'd2
  } pmc_mode_e;
endpackage

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + 1'b1;
  end

  // R7: the settle counter never passes its terminal value
  a_r7_settle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= LAST));
endmodule

// File: rtl/pmc_wake_collect.sv
module pmc_wake_collect #(
  parameter int unsigned NSRC = pmc_pkg::N_WSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] src_en,
  input  logic            capture,
  input  logic            clr_allow,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] cause,
  output logic            wake_hit
);
  logic [NSRC-1:0] cause_q, cause_d, live;

  assign live     = src & src_en;
  assign wake_hit = |live;
  assign cause    = cause_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb begin
      cause_d[i] = cause_q[i];
      if (capture && live[i])        cause_d[i] = 1'b1;
      else if (clr_allow && clr[i])  cause_d[i] = 1'b0;
    end

    // R6: a cause bit only rises for an enabled, active source
    a_r6_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause_q[i]) |-> $past(src[i] && src_en[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  // R9 / R10: outside running mode no collected bit is lost
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_allow |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/pmc_seq_fsm.sv
module pmc_seq_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_idle,
  input  logic       req_deep,
  input  logic       idle_wake,
  input  logic       deep_wake,
  input  logic       save_done,
  input  logic       restore_done,
  input  logic       settle_done,
  output logic       settle_run,
  output logic       capture,
  output logic       clr_allow,
  output logic       cpu_halt,
  output logic       reg_en,
  output logic       gpio_freeze,
  output logic       save_req,
  output logic       restore_req,
  output logic       ser_rx_en,
  output logic       ser_rx_rst,
  output logic [1:0] pwr_mode
);
  pmc_state_e state_q, state_d;
  logic       rx_rst_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE:  if (req_deep) state_d = ST_SAVE;
                  else if (req_idle) state_d = ST_IDLE;
      ST_IDLE:    if (idle_wake) state_d = ST_ACTIVE;
      ST_SAVE:    if (save_done) state_d = ST_FREEZE;
      ST_FREEZE:  state_d = ST_SLEEP;
      ST_SLEEP:   if (deep_wake) state_d = ST_SETTLE;
      ST_SETTLE:  if (settle_done) state_d = ST_RESTORE;
      ST_RESTORE: if (restore_done) state_d = ST_ACTIVE;
      default:    state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_ACTIVE;
      rx_rst_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rx_rst_q <= (state_q == ST_RESTORE) && restore_done;
    end
  end

  always_comb begin
    cpu_halt    = (state_q != ST_ACTIVE);
    reg_en      = (state_q != ST_SLEEP);
    gpio_freeze = (state_q == ST_FREEZE) || (state_q == ST_SLEEP) ||
                  (state_q == ST_SETTLE) || (state_q == ST_RESTORE);
    save_req    = (state_q == ST_SAVE);
    restore_req = (state_q == ST_RESTORE);
    settle_run  = (state_q == ST_SETTLE);
    capture     = (state_q == ST_SLEEP) || (state_q == ST_SETTLE) ||
                  (state_q == ST_RESTORE);
    clr_allow   = (state_q == ST_ACTIVE);
    ser_rx_rst  = rx_rst_q;
    ser_rx_en   = !gpio_freeze && !rx_rst_q;
    unique case (state_q)
      ST_ACTIVE: pwr_mode = MODE_RUN;
      ST_IDLE:   pwr_mode = MODE_IDLE;
      default:   pwr_mode = MODE_DEEP;
    endcase
  end

  // R3: the save request is held until the engine answers
  a_r3_save_held: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !save_done) |=> save_req);
  // R7: the restore request is held until the engine answers
  a_r7_restore_held: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !restore_done) |=> restore_req);
  // R4: pads freeze only after the save completed
  a_r4_freeze_after_save: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpio_freeze) |-> $past(save_done));
  // R8: pads unfreeze only after the restore completed
  a_r8_release_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gpio_freeze) |-> $past(restore_done));
  // R5: regulator off implies frozen pads and halted processor
  a_r5_off_is_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> (gpio_freeze && cpu_halt));
  // R11: no serial reception while frozen
  a_r11_rx_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_freeze |-> !ser_rx_en);
  // R2: idle persists without a qualifying wake
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !idle_wake) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned N_IRQ      = 8,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_idle,
  input  logic              req_deep,
  input  logic [N_IRQ-1:0]  irq_lines,
  input  logic              tmr_wake,
  input  logic              ext_irq,
  input  logic              dbg_wake,
  input  logic              ser_act,
  input  logic              gpio_act,
  input  logic [N_WSRC-1:0] wake_en,
  input  logic [N_WSRC-1:0] cause_clr,
  input  logic              save_done,
  input  logic              restore_done,
  output logic              cpu_halt,
  output logic              reg_en,
  output logic              gpio_freeze,
  output logic              save_req,
  output logic              restore_req,
  output logic              ser_rx_en,
  output logic              ser_rx_rst,
  output logic [N_WSRC-1:0] wake_cause,
  output logic [1:0]        pwr_mode
);
  logic [N_WSRC-1:0] src;
  logic idle_wake, deep_wake, settle_run, settle_done, capture, clr_allow;

  always_comb begin
    src            = '0;
    src[WS_TIMER]  = tmr_wake;
    src[WS_EXTIRQ] = ext_irq;
    src[WS_DEBUG]  = dbg_wake;
    src[WS_SERIAL] = ser_act;
    src[WS_GPIO]   = gpio_act;
  end

  assign idle_wake = (|irq_lines) | ext_irq | tmr_wake | dbg_wake;

  pmc_wake_collect #(.NSRC(N_WSRC)) u_collect (
    .clk(clk), .rst_n(rst_n), .src(src), .src_en(wake_en),
    .capture(capture), .clr_allow(clr_allow), .clr(cause_clr),
    .cause(wake_cause), .wake_hit(deep_wake)
  );

  pmc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(settle_run), .done(settle_done)
  );

  pmc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_deep(req_deep),
    .idle_wake(idle_wake), .deep_wake(deep_wake), .save_done(save_done),
    .restore_done(restore_done), .settle_done(settle_done),
    .settle_run(settle_run), .capture(capture), .clr_allow(clr_allow),
    .cpu_halt(cpu_halt), .reg_en(reg_en), .gpio_freeze(gpio_freeze),
    .save_req(save_req), .restore_req(restore_req), .ser_rx_en(ser_rx_en),
    .ser_rx_rst(ser_rx_rst), .pwr_mode(pwr_mode)
  );

  // R1: out of reset the block is running with nothing pending
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwr_mode == MODE_RUN && wake_cause == '0));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_idle = 0, req_deep = 0, tmr_wake = 0, ext_irq = 0, dbg_wake = 0;
  logic ser_act = 0, gpio_act = 0, save_done = 0, restore_done = 0;
  logic [NI-1:0] irq_lines = '0;
  logic [4:0] wake_en = '0, cause_clr = '0;
  logic cpu_halt, reg_en, gpio_freeze, save_req, restore_req, ser_rx_en, ser_rx_rst;
  logic [4:0] wake_cause;
  logic [1:0] pwr_mode;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { logic [4:0] cause; string req; } exp_t;
  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.N_IRQ(NI), .SETTLE_CYC(SETTLE)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_deep(req_deep),
    .irq_lines(irq_lines), .tmr_wake(tmr_wake), .ext_irq(ext_irq),
    .dbg_wake(dbg_wake), .ser_act(ser_act), .gpio_act(gpio_act),
    .wake_en(wake_en), .cause_clr(cause_clr), .save_done(save_done),
    .restore_done(restore_done), .cpu_halt(cpu_halt), .reg_en(reg_en),
    .gpio_freeze(gpio_freeze), .save_req(save_req), .restore_req(restore_req),
    .ser_rx_en(ser_rx_en), .ser_rx_rst(ser_rx_rst), .wake_cause(wake_cause),
    .pwr_mode(pwr_mode)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // source vector order: 0 timer, 1 ext irq, 2 debug, 3 serial, 4 gpio
  task automatic pulse_src(logic [4:0] v);
    tmr_wake = v[0]; ext_irq = v[1]; dbg_wake = v[2]; ser_act = v[3]; gpio_act = v[4];
    step(1);
    tmr_wake = 0; ext_irq = 0; dbg_wake = 0; ser_act = 0; gpio_act = 0;
  endtask

  task automatic enter_deep(int save_wait, logic with_idle);
    req_deep = 1; req_idle = with_idle;
    step(1);
    req_deep = 0; req_idle = 0;
    chk("R3", "save_req", save_req, 1);
    chk("R3", "mode not idle", pwr_mode, 2);
    repeat (save_wait) begin
      step(1);
      chk("R3", "save_req held", save_req, 1);
      chk("R4", "no early freeze", gpio_freeze, 0);
    end
    save_done = 1;
    step(1);
    save_done = 0;
    chk("R4", "freeze after save", gpio_freeze, 1);
    chk("R4", "reg_en still on", reg_en, 1);
    chk("R11", "rx off when frozen", ser_rx_en, 0);
    step(1);
    chk("R5", "reg_en off in sleep", reg_en, 0);
    chk("R5", "mode deep", pwr_mode, 2);
    chk("R5", "halted", cpu_halt, 1);
  endtask

  task automatic leave_deep(int done_steps, logic [4:0] restore_pulse);
    chk("R7", "reg_en back on", reg_en, 1);
    chk("R7", "still frozen", gpio_freeze, 1);
    step(SETTLE - done_steps);
    chk("R7", "no restore before settle", restore_req, 0);
    step(1);
    chk("R7", "restore_req after settle", restore_req, 1);
    pulse_src(restore_pulse);
    chk("R7", "restore_req held", restore_req, 1);
    restore_done = 1;
    step(1);
    restore_done = 0;
    chk("R8", "running", pwr_mode, 0);
    chk("R8", "unfrozen", gpio_freeze, 0);
    chk("R8", "unhalted", cpu_halt, 0);
    chk("R11", "rx reset pulse", ser_rx_rst, 1);
    chk("R11", "rx still off", ser_rx_en, 0);
    step(1);
    chk("R11", "rx reset done", ser_rx_rst, 0);
    chk("R11", "rx on", ser_rx_en, 1);
  endtask

  // monitor: scoreboard compare on each return from deep sleep to running
  logic [1:0] prev_mode = 2'd0;
  always @(negedge clk) begin
    if (rst_n && prev_mode == 2'd2 && pwr_mode == 2'd0) begin
      if (sbq.size() == 0) chk("R9", "unexpected wake", 1, 0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.req, "wake_cause", wake_cause, e.cause);
      end
    end
    prev_mode = pwr_mode;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk("R1", "mode", pwr_mode, 0);
    chk("R1", "halt", cpu_halt, 0);
    chk("R1", "reg_en", reg_en, 1);
    chk("R1", "freeze", gpio_freeze, 0);
    chk("R1", "reqs", {save_req, restore_req}, 0);
    chk("R1", "rx_en", ser_rx_en, 1);
    chk("R1", "cause", wake_cause, 0);

    // idle entry and exit by an interrupt line
    req_idle = 1; step(1); req_idle = 0;
    chk("R2", "idle mode", pwr_mode, 1);
    chk("R2", "idle halt", cpu_halt, 1);
    chk("R2", "idle reg_en", reg_en, 1);
    pulse_src(5'b11000);
    chk("R2", "serial/gpio keep idle", pwr_mode, 1);
    irq_lines = 8'h08; step(1); irq_lines = '0;
    chk("R2", "irq ends idle", pwr_mode, 0);
    req_idle = 1; step(1); req_idle = 0;
    pulse_src(5'b00100);
    chk("R2", "debug wake ends idle", pwr_mode, 0);
    chk("R2", "idle never captures", wake_cause, 0);

    // deep sleep 1: timer wake, gpio during settle
    wake_en = 5'b11111;
    sbq.push_back('{cause: 5'b10001, req: "R9"});
    enter_deep(3, 1'b0);
    step(2);
    chk("R5", "sleep holds", reg_en, 0);
    pulse_src(5'b00001);
    pulse_src(5'b10000);
    leave_deep(2, 5'b00000);

    // write-one-to-clear while running
    cause_clr = 5'b00001; step(1); cause_clr = '0;
    chk("R10", "clear bit0", wake_cause, 5'b10000);

    // deep sleep 2: only ext irq enabled, clear ignored while asleep
    wake_en = 5'b00010;
    sbq.push_back('{cause: 5'b10010, req: "R6"});
    enter_deep(0, 1'b0);
    pulse_src(5'b11101);
    chk("R6", "masked no wake", reg_en, 0);
    chk("R6", "masked no cause", wake_cause, 5'b10000);
    cause_clr = 5'b11111; step(1); cause_clr = '0;
    chk("R10", "clear ignored asleep", wake_cause, 5'b10000);
    pulse_src(5'b00010);
    leave_deep(1, 5'b00000);
    cause_clr = 5'b11111; step(1); cause_clr = '0;
    chk("R10", "clear all", wake_cause, 0);

    // deep sleep 3: deep wins over idle, serial wake, debug during restore
    wake_en = 5'b11111;
    sbq.push_back('{cause: 5'b01100, req: "R9"});
    enter_deep(1, 1'b1);
    pulse_src(5'b01000);
    leave_deep(1, 5'b00100);

    step(2);
    chk("R9", "scoreboard drained", sbq.size(), 0);
    finish_run();
  end
endmodule